// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside master borrow the shared external bus. The master pulls an active-low hold request; once the request has been synchronised, no disable is in force and no external cycle is in flight, the block lends the bus. It then drives an active-low acknowledge and raises a high-impedance enable, which the pad logic uses to float the address, data and strobe pins.

While the bus is lent, any core access aimed at the external interface gets a not-ready indication. Work that stays inside the chip carries on untouched. A one-bit configuration register, written by software, stops automatic grants. Setting it while the bus is lent takes the bus back on the next clock edge and the pins are driven again. Two status outputs give the synchronised request level and the acknowledge level.

Reset clears the disable bit. If the request is already low while reset is held, the block lends the bus during reset, so the pins float and the acknowledge goes low without waiting for reset to end.

Top module: `xbus_hold_arb`

## Requirements
- R1: With the disable bit clear and `ext_busy` low, a fall of `hold_req_n` drives `hold_ack_n` low and `bus_hiz` high three clock edges later: two synchroniser stages, then the grant register.
- R2: While the effective disable bit is 1, no grant is issued and `hold_ack_n` stays high even with the request low. A write of 0 (`cfg_wr`=1, `cfg_wdata`=0) lets a pending synchronised request be granted on that same clock edge.
- R3: A write of 1 to the disable bit while the bus is lent makes `hold_ack_n` high and `bus_hiz` low at the next clock edge, and they stay so while the request remains low.
- R4: After `hold_req_n` rises, the grant stays for two more edges and ends on the third edge.
- R5: A grant is issued only on an edge where `ext_busy` is low. A request that waits behind a busy external cycle is granted on the first edge after `ext_busy` falls.
- R6: Reset clears the disable bit to 0. If `hold_req_n` is low during a reset held at least three cycles, `hold_ack_n` is low and `bus_hiz` high before reset ends, and the grant stays after release.
- R7: `core_not_ready` is high in the same cycle that `core_ext_req` is high while the bus is lent. It is low whenever the bus is not lent.
- R8: `stat_req_lvl` shows the level of `hold_req_n` two edges after it changes (0 = requesting). `stat_ack_lvl` always equals `hold_ack_n`.
- R9: After a reset with `hold_req_n` high, `hold_ack_n` is high and `bus_hiz` and `core_not_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous hold request from the outside master, active low |
| cfg_wr | input | 1 | Write strobe for the disable bit |
| cfg_wdata | input | 1 | Value written to the disable bit (1 = no automatic grant) |
| ext_busy | input | 1 | An external bus cycle is in flight |
| core_ext_req | input | 1 | Core access aimed at the external interface |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_hiz | output | 1 | 1 = float the external pins and strobes |
| core_not_ready | output | 1 | Stall for a core external access while the bus is lent |
| stat_req_lvl | output | 1 | Synchronised request level |
| stat_ack_lvl | output | 1 | Current acknowledge level |

## Verification
A change on the request pin is due on the status output two edges later and on acknowledge and high-impedance three edges later, in both directions. Disable writes, the fall of `ext_busy` and the end of reset act on the next edge. Not-ready follows `core_ext_req` within the same cycle. Each stimulus pushes its expected outputs into a scoreboard queue, tagged with the edge number at which they are due. A monitor counts edges, samples one nanosecond after each edge and compares only the entries due on that edge. Checks at the edge before a change confirm that results do not come early.

// File: rtl/xbh_pkg.sv
`timescale 1ns/1ps
// Shared types for the external bus hold arbiter.
package xbh_pkg;
    // Bus ownership: kept by the chip, or lent to the outside master.
    typedef enum logic {
        ARB_OWN  = 1'b0,
        ARB_LENT = 1'b1
    } arb_state_e;

    localparam int unsigned XBH_SYNC_STAGES = 2;
endpackage

// File: rtl/xbh_sync.sv
`timescale 1ns/1ps
// Level synchroniser for an asynchronous input.
// Assumes: the input is a slow level; the flops are not reset, so the
// synchronised level stays valid while rst_n is held low.
module xbh_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw input.
                always_ff @(posedge clk) chain[g] <= d_async;
            end else begin : g_next
                // Shift through the next stage.
                always_ff @(posedge clk) chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/xbh_dis_reg.sv
`timescale 1ns/1ps
// Software disable bit for automatic grants.
// Assumes: a write acts in the cycle it is presented. dis_eff gives the
// value in force this cycle, so a write reaches the grant logic at once.
module xbh_dis_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    output logic dis_eff
);
    logic dis_q;

    // Hold the bit; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  dis_q <= 1'b0;
        else if (wr) dis_q <= wdata;
    end

    // Value in force this cycle, with a pending write taking priority.
    always_comb dis_eff = wr ? wdata : dis_q;
endmodule

// File: rtl/xbh_grant_fsm.sv
`timescale 1ns/1ps
// Grant/revoke state machine for lending the external bus.
// Assumes: req_act is already synchronised. The bus is lent only at an
// idle boundary (no busy external cycle). While reset is held the state
// follows the request directly.
module xbh_grant_fsm
    import xbh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_act,
    input  logic dis_eff,
    input  logic ext_busy,
    output logic lent
);
    arb_state_e st_q, st_nx;

    // Next state: lend at an idle boundary; take back on release or disable.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ARB_OWN:  if (req_act && !dis_eff && !ext_busy) st_nx = ARB_LENT;
            ARB_LENT: if (!req_act || dis_eff)              st_nx = ARB_OWN;
            default:                                        st_nx = ARB_OWN;
        endcase
    end

    // State register; during reset the request alone decides.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= req_act ? ARB_LENT : ARB_OWN;
        else        st_q <= st_nx;
    end

    assign lent = (st_q == ARB_LENT);
endmodule

// File: rtl/xbh_stall.sv
`timescale 1ns/1ps
// Core stall generation while the external bus is lent.
// Assumes: core_ext_req is high only for accesses aimed at the external
// interface; internal accesses never reach this block.
module xbh_stall (
    input  logic lent,
    input  logic core_ext_req,
    output logic not_ready
);
    // Hold off external accesses for as long as the bus is lent.
    always_comb not_ready = lent & core_ext_req;
endmodule

// File: rtl/xbus_hold_arb.sv
`timescale 1ns/1ps
// External bus hold arbiter: lends the shared external bus to an outside
// master, floats the pins while it is lent and stalls core external
// accesses during that time.
// Assumes: hold_req_n is asynchronous; ext_busy comes from the local
// bus cycle engine; cfg_wr/cfg_wdata come from the register decode.
module xbus_hold_arb
    import xbh_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = XBH_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic cfg_wr,
    input  logic cfg_wdata,
    input  logic ext_busy,
    input  logic core_ext_req,
    output logic hold_ack_n,
    output logic bus_hiz,
    output logic core_not_ready,
    output logic stat_req_lvl,
    output logic stat_ack_lvl
);
    logic req_lvl_s;
    logic dis_eff;
    logic lent;

    xbh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (hold_req_n),
        .q_sync  (req_lvl_s)
    );

    xbh_dis_reg u_dis (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .dis_eff (dis_eff)
    );

    xbh_grant_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_act  (~req_lvl_s),
        .dis_eff  (dis_eff),
        .ext_busy (ext_busy),
        .lent     (lent)
    );

    xbh_stall u_stall (
        .lent         (lent),
        .core_ext_req (core_ext_req),
        .not_ready    (core_not_ready)
    );

    // Drive the acknowledge, pin float enable and status levels.
    always_comb begin
        hold_ack_n   = ~lent;
        bus_hiz      = lent;
        stat_req_lvl = req_lvl_s;
        stat_ack_lvl = ~lent;
    end
endmodule

// File: rtl/xbh_checker.sv
`timescale 1ns/1ps
// Property checker for xbus_hold_arb; connects through bind and sees only ports.
module xbh_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_wdata,
    input logic ext_busy,
    input logic core_ext_req,
    input logic hold_ack_n,
    input logic core_not_ready,
    input logic stat_req_lvl
);
    AST_GRANT_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_ack_n) && $past(rst_n)) |-> ($past(!ext_busy) && !$past(stat_req_lvl))); // R5

    AST_NO_GRANT_ON_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_ack_n) && $past(rst_n)) |-> !$past(cfg_wr && cfg_wdata)); // R2

    AST_DIS_REVOKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata) |=> hold_ack_n); // R3

    AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_req_lvl |=> hold_ack_n); // R4

    AST_STALL_ONLY_LENT: assert property (@(posedge clk) disable iff (!rst_n)
        core_not_ready |-> (core_ext_req && !hold_ack_n)); // R7
endmodule

bind xbus_hold_arb xbh_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .ext_busy       (ext_busy),
    .core_ext_req   (core_ext_req),
    .hold_ack_n     (hold_ack_n),
    .core_not_ready (core_not_ready),
    .stat_req_lvl   (stat_req_lvl)
);

// File: tb/tb_xbus_hold_arb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected outputs due at an edge count,
// monitor compares them 1 ns after that edge.
module tb_xbus_hold_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b1;
    logic cfg_wr = 1'b0;
    logic cfg_wdata = 1'b0;
    logic ext_busy = 1'b0;
    logic core_ext_req = 1'b0;
    logic hold_ack_n, bus_hiz, core_not_ready, stat_req_lvl, stat_ack_lvl;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        bit    grant;
        bit    nrdy;
        bit    sreq;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5ns clk = ~clk;

    xbus_hold_arb dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hold_req_n     (hold_req_n),
        .cfg_wr         (cfg_wr),
        .cfg_wdata      (cfg_wdata),
        .ext_busy       (ext_busy),
        .core_ext_req   (core_ext_req),
        .hold_ack_n     (hold_ack_n),
        .bus_hiz        (bus_hiz),
        .core_not_ready (core_not_ready),
        .stat_req_lvl   (stat_req_lvl),
        .stat_ack_lvl   (stat_ack_lvl)
    );

    // Monitor: count edges and compare the entries due on this edge.
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            cyc++;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    checks++;
                    if (hold_ack_n !== ~sb[i].grant || bus_hiz !== sb[i].grant ||
                        core_not_ready !== sb[i].nrdy || stat_req_lvl !== sb[i].sreq ||
                        stat_ack_lvl !== ~sb[i].grant) begin
                        errors++;
                        $display("FAIL %s @%0d: ack_n=%0b hiz=%0b nrdy=%0b sreq=%0b sack=%0b expected grant=%0b nrdy=%0b sreq=%0b",
                                 sb[i].tag, cyc, hold_ack_n, bus_hiz, core_not_ready,
                                 stat_req_lvl, stat_ack_lvl, sb[i].grant, sb[i].nrdy, sb[i].sreq);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: expectation due lat edges after the current negedge.
    task automatic expect_after(input int lat, input bit g, input bit nr, input bit sr, input string tag);
        exp_t e;
        e.due = cyc + lat; e.grant = g; e.nrdy = nr; e.sreq = sr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic cfg_write(input bit v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step(1);
        cfg_wr = 1'b0;
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        expect_after(1, 0, 0, 1, "R9 reset idle");
        step(3);

        // R1 / R8: request fall
        hold_req_n = 1'b0;
        expect_after(2, 0, 0, 0, "R8 status before grant");
        expect_after(3, 1, 0, 0, "R1 grant");
        step(4);
        // R7: stall while lent
        core_ext_req = 1'b1;
        expect_after(1, 1, 1, 0, "R7 stall");
        step(2);
        // R4: release
        hold_req_n = 1'b1;
        expect_after(2, 1, 1, 1, "R4 grant still held");
        expect_after(3, 0, 0, 1, "R4 release");
        step(4);
        core_ext_req = 1'b0;

        // R2: disabled blocks grant, clearing regrants
        cfg_write(1'b1);
        hold_req_n = 1'b0;
        expect_after(5, 0, 0, 0, "R2 blocked");
        step(6);
        cfg_wr = 1'b1; cfg_wdata = 1'b0;
        expect_after(1, 1, 0, 0, "R2 regrant");
        step(1);
        cfg_wr = 1'b0;
        step(2);

        // R3: revoke while lent
        cfg_wr = 1'b1; cfg_wdata = 1'b1;
        expect_after(1, 0, 0, 0, "R3 revoke");
        step(1);
        cfg_wr = 1'b0;
        expect_after(3, 0, 0, 0, "R3 stays revoked");
        step(4);
        core_ext_req = 1'b1;
        expect_after(1, 0, 0, 0, "R7 no stall when not lent");
        step(1);
        core_ext_req = 1'b0;
        cfg_wr = 1'b1; cfg_wdata = 1'b0;
        expect_after(1, 1, 0, 0, "R2 regrant after revoke");
        step(1);
        cfg_wr = 1'b0;
        hold_req_n = 1'b1;
        step(5);

        // R5: wait for idle boundary
        ext_busy = 1'b1;
        hold_req_n = 1'b0;
        expect_after(5, 0, 0, 0, "R5 waits on busy");
        step(6);
        ext_busy = 1'b0;
        expect_after(1, 1, 0, 0, "R5 grant after busy");
        step(2);
        hold_req_n = 1'b1;
        step(5);

        // R6: reset with request low, disable set beforehand
        cfg_write(1'b1);
        hold_req_n = 1'b0;
        rst_n = 1'b0;
        expect_after(4, 1, 0, 0, "R6 grant during reset");
        step(5);
        rst_n = 1'b1;
        expect_after(2, 1, 0, 0, "R6 grant after reset");
        step(3);
        hold_req_n = 1'b1;
        expect_after(3, 0, 0, 1, "R4 release after reset");
        step(5);

        while (sb.size() != 0) step(1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule